// File: doc/BRIEF.md
# Event-Type Handler Dispatch Unit

This block runs on a monitoring core. It feeds decoded event records to the handler routines that process them, one record at a time. Each record comes from an in-order buffer and carries an event type, a program counter, an operand address and source/destination flags. Software fills a small table that maps each event type to a handler entry address, with a valid bit per entry. When the running handler raises its "next event" request, the block issues the following mapped record. Issuing a record means three things: a one-cycle start pulse, the handler target address, and the record fields held in argument registers.

The block keeps one look-ahead slot at the head of the buffer. The table lookup is done when a record enters this slot, so the target is already known before the current handler finishes. If the request arrives while a resolved record is waiting, the next issue follows with no idle cycle. Records whose type has no valid entry are dropped from the slot without being issued. If no mapped record is waiting, the request leaves the block idle, and the next mapped record that arrives is issued without a further request.

Top module: `evt_dispatch_unit`

## Requirements
- R1: After reset, `busy`, `hdl_go` and `look_valid` are 0, `rec_ready` is 1, and every table entry is invalid.
- R2: A table write (`cfg_we`=1) sets entry `cfg_idx` to address `cfg_addr`, with the valid bit taken from `cfg_live`. A record whose type selects a valid entry is issued with `hdl_target` equal to that entry's address.
- R3: If the head record maps to a valid entry and the block is idle, or `nxt_req` is 1 while busy, then in the next cycle `hdl_go` is 1 for exactly one cycle and `busy` is 1.
- R4: `arg_type`, `arg_pc`, `arg_addr` and `arg_flags` present the issued record's fields from the cycle `hdl_go` is 1. They hold until the next issue.
- R5: Records are issued strictly in the order they were accepted.
- R6: A record whose type selects an invalid entry is consumed and never produces `hdl_go`.
- R7: `nxt_req` while busy, with no mapped record at the head, clears `busy`. The next mapped record to arrive is then issued with no further request.
- R8: While the head slot holds a mapped record, `look_valid` is 1 and `look_target` shows its resolved handler address. These stay steady until the record is issued.
- R9: `nxt_req` while idle has no effect.
- R10: A table write is taken only when the block is idle and the head slot is empty. Otherwise it is discarded.
- R11: `nxt_req` while busy, with a mapped record already resolved at the head, gives `hdl_go` in the very next cycle, so issues run back to back.
- R12: `rec_ready` is 1 when the head slot is empty or is being vacated in the same cycle (issued or dropped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Table entry (event type) to write |
| cfg_addr | input | 32 | Handler entry address to store |
| cfg_live | input | 1 | Valid bit to store |
| rec_valid | input | 1 | Buffer offers a record |
| rec_ready | output | 1 | Record accepted this cycle when valid |
| rec_type | input | 4 | Record event type |
| rec_pc | input | 32 | Record program counter |
| rec_addr | input | 32 | Record operand virtual address |
| rec_flags | input | 4 | Record source/destination operand flags |
| nxt_req | input | 1 | Running handler finished, wants next event |
| hdl_go | output | 1 | One-cycle handler start pulse |
| hdl_target | output | 32 | Handler entry address to jump to |
| arg_type | output | 4 | Argument register: event type |
| arg_pc | output | 32 | Argument register: program counter |
| arg_addr | output | 32 | Argument register: operand address |
| arg_flags | output | 4 | Argument register: operand flags |
| busy | output | 1 | A handler is running |
| look_valid | output | 1 | Head slot holds a resolved mapped record |
| look_target | output | 32 | Pre-resolved target of the head record |

## Verification
The properties assume that `nxt_req` comes only from the handler that was started. They do not assume that inputs stay stable across clock edges, because the design registers every decision. The properties also rely on the buffer presenting a record's fields unchanged while `rec_valid` is held and the record is not yet accepted. The bench meets this by driving all inputs from a single process at the falling edge, taking each record from a queue that is popped only when `rec_ready` was seen high. A separate drive path pulses `nxt_req` while idle and writes the table while busy, to exercise R9 and R10.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int TYPE_W_D = 4;
  localparam int ADDR_W_D = 32;
  localparam int FLAG_W_D = 4;

  // head record leaves by issue: mapped, and either idle or handler done
  function automatic logic issue_now(logic head_v, logic head_hit,
                                     logic running, logic done);
    return head_v && head_hit && (!running || done);
  endfunction

  // unmapped head record is discarded regardless of handler state
  function automatic logic drop_now(logic head_v, logic head_hit);
    return head_v && !head_hit;
  endfunction

  // table may change only with nothing in flight
  function automatic logic cfg_open(logic running, logic head_v);
    return !running && !head_v;
  endfunction

  // running flag next value
  function automatic logic run_next(logic running, logic issue, logic done);
    return issue ? 1'b1 : (done ? 1'b0 : running);
  endfunction
endpackage

// File: rtl/evt_cfg_table.sv
module evt_cfg_table #(
  parameter int TYPE_W = evt_pkg::TYPE_W_D,
  parameter int ADDR_W = evt_pkg::ADDR_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TYPE_W-1:0] wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_live,
  input  logic [TYPE_W-1:0] rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit
);
  localparam int ENTRIES = 1 << TYPE_W;

  logic [ADDR_W-1:0] ent_addr [ENTRIES];
  logic [ENTRIES-1:0] ent_live;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == TYPE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr[g] <= '0;
        ent_live[g] <= 1'b0;
      end else if (sel) begin
        ent_addr[g] <= wr_addr;
        ent_live[g] <= wr_live;
      end
    end
  end

  assign rd_addr = ent_addr[rd_idx];
  assign rd_hit  = ent_live[rd_idx];
endmodule

// File: rtl/evt_lookahead.sv
module evt_lookahead #(
  parameter int TYPE_W = evt_pkg::TYPE_W_D,
  parameter int ADDR_W = evt_pkg::ADDR_W_D,
  parameter int FLAG_W = evt_pkg::FLAG_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [ADDR_W-1:0] in_tgt,
  input  logic              in_hit,
  input  logic              pop,
  output logic              in_ready,
  output logic              drop,
  output logic              h_v,
  output logic              h_hit,
  output logic [TYPE_W-1:0] h_type,
  output logic [ADDR_W-1:0] h_pc,
  output logic [ADDR_W-1:0] h_addr,
  output logic [FLAG_W-1:0] h_flags,
  output logic [ADDR_W-1:0] h_tgt
);
  logic leave;
  logic load;

  assign drop     = evt_pkg::drop_now(h_v, h_hit);
  assign leave    = drop || pop;
  assign in_ready = !h_v || leave;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_v     <= 1'b0;
      h_hit   <= 1'b0;
      h_type  <= '0;
      h_pc    <= '0;
      h_addr  <= '0;
      h_flags <= '0;
      h_tgt   <= '0;
    end else if (load) begin
      h_v     <= 1'b1;
      h_hit   <= in_hit;
      h_type  <= in_type;
      h_pc    <= in_pc;
      h_addr  <= in_addr;
      h_flags <= in_flags;
      h_tgt   <= in_tgt;
    end else if (leave) begin
      h_v     <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_issue.sv
module evt_issue #(
  parameter int TYPE_W = evt_pkg::TYPE_W_D,
  parameter int ADDR_W = evt_pkg::ADDR_W_D,
  parameter int FLAG_W = evt_pkg::FLAG_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              done,
  input  logic [TYPE_W-1:0] s_type,
  input  logic [ADDR_W-1:0] s_pc,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [FLAG_W-1:0] s_flags,
  input  logic [ADDR_W-1:0] s_tgt,
  output logic              running,
  output logic              go,
  output logic [ADDR_W-1:0] target,
  output logic [TYPE_W-1:0] a_type,
  output logic [ADDR_W-1:0] a_pc,
  output logic [ADDR_W-1:0] a_addr,
  output logic [FLAG_W-1:0] a_flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      go      <= 1'b0;
    end else begin
      running <= evt_pkg::run_next(running, take, done);
      go      <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target  <= '0;
      a_type  <= '0;
      a_pc    <= '0;
      a_addr  <= '0;
      a_flags <= '0;
    end else if (take) begin
      target  <= s_tgt;
      a_type  <= s_type;
      a_pc    <= s_pc;
      a_addr  <= s_addr;
      a_flags <= s_flags;
    end
  end
endmodule

// File: rtl/evt_dispatch_unit.sv
module evt_dispatch_unit #(
  parameter int TYPE_W = evt_pkg::TYPE_W_D,
  parameter int ADDR_W = evt_pkg::ADDR_W_D,
  parameter int FLAG_W = evt_pkg::FLAG_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TYPE_W-1:0] cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_live,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [TYPE_W-1:0] rec_type,
  input  logic [ADDR_W-1:0] rec_pc,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [FLAG_W-1:0] rec_flags,
  input  logic              nxt_req,
  output logic              hdl_go,
  output logic [ADDR_W-1:0] hdl_target,
  output logic [TYPE_W-1:0] arg_type,
  output logic [ADDR_W-1:0] arg_pc,
  output logic [ADDR_W-1:0] arg_addr,
  output logic [FLAG_W-1:0] arg_flags,
  output logic              busy,
  output logic              look_valid,
  output logic [ADDR_W-1:0] look_target
);
  // named internal events, visible to the bound checker
  logic              take_w;
  logic              drop_w;
  logic              cfg_take_w;
  logic [ADDR_W-1:0] lu_addr;
  logic              lu_hit;
  logic              h_v, h_hit;
  logic [TYPE_W-1:0] h_type;
  logic [ADDR_W-1:0] h_pc, h_addr, h_tgt;
  logic [FLAG_W-1:0] h_flags;

  assign cfg_take_w = cfg_we && evt_pkg::cfg_open(busy, h_v);
  assign take_w     = evt_pkg::issue_now(h_v, h_hit, busy, nxt_req);

  evt_cfg_table #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_take_w), .wr_idx(cfg_idx), .wr_addr(cfg_addr), .wr_live(cfg_live),
    .rd_idx(rec_type), .rd_addr(lu_addr), .rd_hit(lu_hit)
  );

  evt_lookahead #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_look (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rec_valid), .in_type(rec_type), .in_pc(rec_pc), .in_addr(rec_addr),
    .in_flags(rec_flags), .in_tgt(lu_addr), .in_hit(lu_hit), .pop(take_w),
    .in_ready(rec_ready), .drop(drop_w),
    .h_v(h_v), .h_hit(h_hit), .h_type(h_type), .h_pc(h_pc), .h_addr(h_addr),
    .h_flags(h_flags), .h_tgt(h_tgt)
  );

  evt_issue #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_iss (
    .clk(clk), .rst_n(rst_n), .take(take_w), .done(nxt_req),
    .s_type(h_type), .s_pc(h_pc), .s_addr(h_addr), .s_flags(h_flags), .s_tgt(h_tgt),
    .running(busy), .go(hdl_go), .target(hdl_target),
    .a_type(arg_type), .a_pc(arg_pc), .a_addr(arg_addr), .a_flags(arg_flags)
  );

  assign look_valid  = h_v && h_hit;
  assign look_target = h_tgt;
endmodule

// File: rtl/evt_dispatch_chk.sv
module evt_dispatch_chk #(
  parameter int ADDR_W = evt_pkg::ADDR_W_D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdl_go,
  input logic              busy,
  input logic              nxt_req,
  input logic              rec_ready,
  input logic              look_valid,
  input logic [ADDR_W-1:0] look_target,
  input logic [ADDR_W-1:0] hdl_target,
  input logic [ADDR_W-1:0] arg_pc,
  input logic              drop_w,
  input logic              cfg_take_w
);
  p_go_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_go |-> busy);

  p_args_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !nxt_req |=> !hdl_go && $stable(arg_pc) && $stable(hdl_target));

  p_skip_nogo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> !hdl_go);

  p_look_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid && busy && !nxt_req |=> look_valid && $stable(look_target));

  p_idle_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !look_valid && nxt_req |=> !busy && !hdl_go);

  p_cfg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take_w |=> !hdl_go);

  p_back2back_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && nxt_req && look_valid |=> hdl_go);

  p_stall_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_ready |-> look_valid && busy);
endmodule

bind evt_dispatch_unit evt_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdl_go(hdl_go), .busy(busy), .nxt_req(nxt_req),
  .rec_ready(rec_ready), .look_valid(look_valid), .look_target(look_target),
  .hdl_target(hdl_target), .arg_pc(arg_pc), .drop_w(drop_w), .cfg_take_w(cfg_take_w)
);

// File: tb/sim_evt_dispatch_unit.sv
module sim_evt_dispatch_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0]  t;
    logic [31:0] pc;
    logic [31:0] a;
    logic [3:0]  f;
  } rec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_live = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [31:0] cfg_addr = '0;
  logic rec_valid = 1'b0;
  logic rec_ready;
  logic [3:0] rec_type = '0, rec_flags = '0;
  logic [31:0] rec_pc = '0, rec_addr = '0;
  logic nxt_req = 1'b0;
  logic hdl_go, busy, look_valid;
  logic [31:0] hdl_target, arg_pc, arg_addr, look_target;
  logic [3:0] arg_type, arg_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_dispatch_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
    .cfg_live(cfg_live), .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_type(rec_type),
    .rec_pc(rec_pc), .rec_addr(rec_addr), .rec_flags(rec_flags), .nxt_req(nxt_req),
    .hdl_go(hdl_go), .hdl_target(hdl_target), .arg_type(arg_type), .arg_pc(arg_pc),
    .arg_addr(arg_addr), .arg_flags(arg_flags), .busy(busy), .look_valid(look_valid),
    .look_target(look_target)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] m_taddr [16];
  bit          m_tlive [16];
  bit          m_hv, m_hhit, m_busy, m_go;
  rec_t        m_head, m_arg;
  logic [31:0] m_htgt, m_tgt;

  // stimulus state
  rec_t rq[$];
  logic [31:0] exp_pc[$];
  int hold_len = 0, hcnt = 0;
  bit handler_on = 1'b1;
  bit poke_idle = 1'b0;
  bit w_en = 1'b0, w_live = 1'b0;
  int w_idx = 0;
  logic [31:0] w_addr = '0;
  int go_total = 0, b2b = 0;
  bit prev_go = 1'b0;

  task automatic push(input int t, input logic [31:0] pc);
    rec_t r;
    r.t = 4'(t); r.pc = pc; r.a = pc ^ 32'h5A5A_0000; r.f = 4'(pc[3:0] ^ 4'(t));
    rq.push_back(r);
    if (m_tlive[t]) exp_pc.push_back(pc);
  endtask

  task automatic step();
    bit take, drop, leave, ready, acc, wok;
    @(negedge clk);
    // registered outputs against the model
    chk(hdl_go === m_go, "R3", "hdl_go", hdl_go, m_go);
    chk(busy === m_busy, "R7", "busy", busy, m_busy);
    chk(look_valid === (m_hv && m_hhit), "R8", "look_valid", look_valid, m_hv && m_hhit);
    if (m_hv && m_hhit) chk(look_target === m_htgt, "R8", "look_target", look_target, m_htgt);
    if (m_go) begin
      chk(hdl_target === m_tgt, "R2", "hdl_target", hdl_target, m_tgt);
      chk(arg_pc === m_arg.pc && arg_addr === m_arg.a && arg_type === m_arg.t &&
          arg_flags === m_arg.f, "R4", "arg_pc", arg_pc, m_arg.pc);
      if (exp_pc.size() > 0) begin
        chk(arg_pc === exp_pc[0], "R5", "issue order pc", arg_pc, exp_pc[0]);
        void'(exp_pc.pop_front());
      end else chk(1'b0, "R6", "unexpected issue pc", arg_pc, 0);
      go_total++;
      if (prev_go) b2b++;
    end
    prev_go = m_go;
    // handler behaviour
    if (m_go) hcnt = hold_len;
    nxt_req = (handler_on && m_busy && hcnt == 0) || (poke_idle && !m_busy);
    if (m_busy && hcnt > 0 && !m_go) hcnt--;
    // drive inputs
    rec_valid = rq.size() > 0;
    if (rec_valid) begin
      rec_type = rq[0].t; rec_pc = rq[0].pc; rec_addr = rq[0].a; rec_flags = rq[0].f;
    end
    cfg_we = w_en; cfg_idx = 4'(w_idx); cfg_addr = w_addr; cfg_live = w_live;
    #1;
    take  = m_hv && m_hhit && (!m_busy || nxt_req);
    drop  = m_hv && !m_hhit;
    leave = take || drop;
    ready = !m_hv || leave;
    chk(rec_ready === ready, "R12", "rec_ready", rec_ready, ready);
    acc = rec_valid && ready;
    wok = w_en && !m_busy && !m_hv;
    // model next state
    m_go = take;
    if (take) begin m_tgt = m_htgt; m_arg = m_head; end
    m_busy = take ? 1'b1 : (nxt_req ? 1'b0 : m_busy);
    if (acc) begin
      m_head = rq[0]; m_hv = 1'b1;
      m_htgt = m_taddr[rq[0].t]; m_hhit = m_tlive[rq[0].t];
      void'(rq.pop_front());
    end else if (leave) m_hv = 1'b0;
    if (wok) begin m_taddr[w_idx] = w_addr; m_tlive[w_idx] = w_live; end
    w_en = 1'b0;
  endtask

  task automatic twrite(input int idx, input logic [31:0] addr, input bit live);
    w_en = 1'b1; w_idx = idx; w_addr = addr; w_live = live;
    step();
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_taddr[i] = '0; m_tlive[i] = 1'b0; end
    m_hv = 0; m_hhit = 0; m_busy = 0; m_go = 0; m_htgt = '0; m_tgt = '0;
    m_head = '{default: '0}; m_arg = '{default: '0};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && hdl_go === 1'b0, "R1", "busy/go at reset", {busy, hdl_go}, 0);
    chk(look_valid === 1'b0 && rec_ready === 1'b1, "R1", "look/ready at reset",
        {look_valid, rec_ready}, 1);
    rst_n = 1'b1;
    // R1: no entry valid, so records are only dropped
    push(4, 32'h100); push(9, 32'h104);
    drain(6);
    chk(go_total == 0, "R1", "issues before programming", go_total, 0);
    // R2: program table
    twrite(1, 32'h8000_1000, 1); twrite(2, 32'h8000_2000, 1);
    twrite(5, 32'h8000_5000, 1); twrite(15, 32'h8000_F000, 1);
    twrite(3, 32'h8000_3000, 1); twrite(3, 32'h8000_3000, 0);
    // R3/R4/R5/R6: mixed stream, slow handler
    hold_len = 3;
    for (int i = 0; i < 24; i++) push((i * 7) % 16, 32'h1000 + 32'(i * 4));
    drain(150);
    chk(exp_pc.size() == 0, "R5", "pending issues after slow stream", exp_pc.size(), 0);
    // R11: back to back with immediate handler
    hold_len = 0; b2b = 0;
    for (int i = 0; i < 12; i++) push((i % 2 == 0) ? 1 : 5, 32'h2000 + 32'(i * 4));
    drain(40);
    chk(b2b >= 10, "R11", "back-to-back issue pairs", b2b, 10);
    // R7: empty buffer stall, then late arrival issues without request
    drain(5);
    chk(busy === 1'b0, "R7", "busy after drain", busy, 0);
    push(2, 32'h3000);
    drain(6);
    chk(exp_pc.size() == 0, "R7", "late record issued", exp_pc.size(), 0);
    // R9: request while idle
    handler_on = 1'b0; drain(4);
    handler_on = 1'b1; drain(4);
    poke_idle = 1'b1; handler_on = 1'b0;
    drain(6);
    chk(busy === 1'b0 && hdl_go === 1'b0, "R9", "idle request effect", {busy, hdl_go}, 0);
    poke_idle = 1'b0; handler_on = 1'b1;
    // R10: write while busy is discarded
    handler_on = 1'b0; hold_len = 0;
    push(15, 32'h4000);
    drain(4);
    chk(busy === 1'b1, "R10", "busy before write", busy, 1);
    twrite(15, 32'hDEAD_0000, 1);
    handler_on = 1'b1;
    drain(4);
    push(15, 32'h4004);
    drain(3);
    for (int i = 0; i < 3 && !(hdl_go === 1'b1); i++) step();
    chk(hdl_target === 32'h8000_F000, "R10", "target after busy write", hdl_target,
        32'h8000_F000);
    drain(10);
    // R6: unmapped-only burst
    go_total = 0;
    for (int i = 0; i < 6; i++) push((i % 2 == 0) ? 3 : 8, 32'h5000 + 32'(i * 4));
    drain(20);
    chk(go_total == 0, "R6", "issues for unmapped burst", go_total, 0);
    chk(exp_pc.size() == 0, "R5", "leftover expected issues", exp_pc.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule